// File: doc/BRIEF.md
# Step-Driven Timer with Compare Interrupt

This block keeps a running tally of executed instruction steps and raises a timer interrupt pending flag when the tally reaches a value that software has programmed. Inside, the counter is one bit wider than the value software sees. It advances by one on each step, so the visible count moves forward once every two steps. The compare value is matched against the internal counter after being doubled, meaning after a one-bit left shift.

A match sets a sticky pending flag and sends a one-cycle strobe. The strobe tells the surrounding interrupt logic to look at its inputs again. Software can load the count, load the compare value (which also drops the pending flag), or clear the flag directly. Masking, enable gating and exception entry belong to the interrupt logic outside this block. All pins are plain control and status levels; no data stream crosses the boundary, so there is no valid/ready handshake.

Top module: `tick_cmp_timer`

## Requirements
- R1: While `rst_n` is low, and in the first cycle after it rises, `count_vis` is 0, `timer_pend` is 0 and `reeval_stb` is 0. The compare register is also reset to 0.
- R2: When `step_en` is high and `cnt_wr_en` is low, the internal (VIS_W+1)-bit counter increases by one at the clock edge. `count_vis` shows internal bits [VIS_W:1], so it advances once every two steps.
- R3: When neither `step_en` nor `cnt_wr_en` is high, the internal counter and `count_vis` hold their values.
- R4: `cnt_wr_en` loads the internal counter with `cnt_wr_data` shifted left by one bit. `count_vis` equals `cnt_wr_data` after that edge. A load takes priority over a step in the same cycle.
- R5: `cmp_wr_en` loads the compare register from `cmp_wr_data` and clears `timer_pend` at that edge. No match is taken in a cycle that writes the compare register.
- R6: A match occurs in a cycle where a step is taken (no count write and no compare write) and the incremented internal counter equals the compare register shifted left by one bit. After that edge, `timer_pend` is 1.
- R7: `timer_pend` stays at 1 until `pend_clr` or `cmp_wr_en` is high at an edge. A match in the same cycle as `pend_clr` leaves it at 1.
- R8: The internal counter wraps modulo 2^(VIS_W+1). From an all-ones visible count, the counter passes through zero, and a compare value of 0 matches at that wrap.
- R9: `reeval_stb` is high for exactly the one cycle after each match edge, and low at all other times.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| step_en | input | 1 | One instruction step taken this cycle |
| cnt_wr_en | input | 1 | Software load of the visible count |
| cnt_wr_data | input | VIS_W | Value for the visible count |
| cmp_wr_en | input | 1 | Software load of the compare register |
| cmp_wr_data | input | VIS_W | New compare value |
| pend_clr | input | 1 | Clear the pending flag |
| timer_pend | output | 1 | Timer interrupt pending level |
| reeval_stb | output | 1 | One-cycle strobe: re-evaluate interrupt line |
| count_vis | output | VIS_W | Software-visible count, internal bits [VIS_W:1] |

## Verification
The bench builds the block with VIS_W = 8, so the internal counter is nine bits wide. This brings the full wrap through zero within a few steps of a count load. A compare value of zero can therefore be seen matching at the wrap, and the odd and even internal phases behind each visible value are exercised alongside clear-versus-match collisions.

// File: rtl/tct_pkg.sv
package tct_pkg;
  // action the counter takes at the next edge
  typedef enum logic [1:0] {
    CTR_HOLD = 2'd0,
    CTR_STEP = 2'd1,
    CTR_LOAD = 2'd2
  } ctr_op_e;
endpackage

// File: rtl/tct_counter.sv
module tct_counter
  import tct_pkg::*;
#(
  parameter int VIS_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  ctr_op_e          op,
  input  logic [VIS_W-1:0] load_val,
  output logic [VIS_W:0]   ctr_q,
  output logic [VIS_W:0]   ctr_inc
);
  localparam int CW = VIS_W + 1;
  localparam logic [CW-1:0] ONE = {{VIS_W{1'b0}}, 1'b1};

  // natural wrap modulo 2^CW
  assign ctr_inc = ctr_q + ONE;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctr_q <= '0;
    end else begin
      unique case (op)
        CTR_LOAD: ctr_q <= {load_val, 1'b0};
        CTR_STEP: ctr_q <= ctr_inc;
        default:  ctr_q <= ctr_q;
      endcase
    end
  end
endmodule

// File: rtl/tct_match.sv
module tct_match #(
  parameter int VIS_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cmp_wr_en,
  input  logic [VIS_W-1:0] cmp_wr_data,
  input  logic             step_ok,
  input  logic [VIS_W:0]   ctr_inc,
  output logic [VIS_W-1:0] cmp_q,
  output logic             hit
);
  // compare value lives in doubled units of the internal counter
  logic [VIS_W:0] target;
  assign target = {cmp_q, 1'b0};
  assign hit    = step_ok && (ctr_inc == target);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         cmp_q <= '0;
    else if (cmp_wr_en) cmp_q <= cmp_wr_data;
  end
endmodule

// File: rtl/tct_pending.sv
module tct_pending (
  input  logic clk,
  input  logic rst_n,
  input  logic hit,
  input  logic pend_clr,
  input  logic cmp_wr_en,
  output logic pend_q,
  output logic stb_q
);
  logic keep;
  assign keep = pend_q && !pend_clr && !cmp_wr_en;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q <= 1'b0;
      stb_q  <= 1'b0;
    end else begin
      pend_q <= hit || keep;   // a fresh match outranks the clear
      stb_q  <= hit;
    end
  end
endmodule

// File: rtl/tick_cmp_timer.sv
module tick_cmp_timer
  import tct_pkg::*;
#(
  parameter int VIS_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             step_en,
  input  logic             cnt_wr_en,
  input  logic [VIS_W-1:0] cnt_wr_data,
  input  logic             cmp_wr_en,
  input  logic [VIS_W-1:0] cmp_wr_data,
  input  logic             pend_clr,
  output logic             timer_pend,
  output logic             reeval_stb,
  output logic [VIS_W-1:0] count_vis
);
  ctr_op_e          op;
  logic [VIS_W:0]   ctr_q;
  logic [VIS_W:0]   ctr_inc;
  logic [VIS_W-1:0] cmp_q;
  logic             hit;
  logic             step_ok;

  always_comb begin
    if (cnt_wr_en)    op = CTR_LOAD;
    else if (step_en) op = CTR_STEP;
    else              op = CTR_HOLD;
  end

  assign step_ok = (op == CTR_STEP) && !cmp_wr_en;

  tct_counter #(.VIS_W(VIS_W)) u_ctr (
    .clk      (clk),
    .rst_n    (rst_n),
    .op       (op),
    .load_val (cnt_wr_data),
    .ctr_q    (ctr_q),
    .ctr_inc  (ctr_inc)
  );

  tct_match #(.VIS_W(VIS_W)) u_match (
    .clk         (clk),
    .rst_n       (rst_n),
    .cmp_wr_en   (cmp_wr_en),
    .cmp_wr_data (cmp_wr_data),
    .step_ok     (step_ok),
    .ctr_inc     (ctr_inc),
    .cmp_q       (cmp_q),
    .hit         (hit)
  );

  tct_pending u_pend (
    .clk       (clk),
    .rst_n     (rst_n),
    .hit       (hit),
    .pend_clr  (pend_clr),
    .cmp_wr_en (cmp_wr_en),
    .pend_q    (timer_pend),
    .stb_q     (reeval_stb)
  );

  assign count_vis = ctr_q[VIS_W:1];
endmodule

// File: rtl/tct_chk.sv
module tct_chk #(
  parameter int VIS_W = 32
) (
  input logic             clk,
  input logic             rst_n,
  input logic             step_en,
  input logic             cnt_wr_en,
  input logic [VIS_W-1:0] cnt_wr_data,
  input logic             cmp_wr_en,
  input logic             timer_pend,
  input logic             reeval_stb,
  input logic [VIS_W-1:0] count_vis,
  input logic [VIS_W:0]   ctr_q,
  input logic [VIS_W-1:0] cmp_q
);
  localparam logic [VIS_W:0] ONE = {{VIS_W{1'b0}}, 1'b1};

  // R2
  step_adv_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (step_en && !cnt_wr_en) |=> ctr_q == $past(ctr_q) + ONE);

  // R3
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!step_en && !cnt_wr_en) |=> $stable(ctr_q));

  // R4
  cnt_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_wr_en |=> count_vis == $past(cnt_wr_data));

  // R5
  cmp_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cmp_wr_en |=> !timer_pend);

  // R6
  match_value_chk: assert property (@(posedge clk) disable iff (!rst_n)
    reeval_stb |-> (ctr_q == {cmp_q, 1'b0}) && timer_pend);

  // R9
  rise_has_stb_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(timer_pend) |-> reeval_stb);
endmodule

bind tick_cmp_timer tct_chk #(.VIS_W(VIS_W)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .step_en     (step_en),
  .cnt_wr_en   (cnt_wr_en),
  .cnt_wr_data (cnt_wr_data),
  .cmp_wr_en   (cmp_wr_en),
  .timer_pend  (timer_pend),
  .reeval_stb  (reeval_stb),
  .count_vis   (count_vis),
  .ctr_q       (ctr_q),
  .cmp_q       (cmp_q)
);

// File: tb/sim_tick_cmp_timer.sv
`timescale 1ns/1ps
module sim_tick_cmp_timer;
  localparam int W = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic step_en = 1'b0, cnt_wr_en = 1'b0, cmp_wr_en = 1'b0, pend_clr = 1'b0;
  logic [W-1:0] cnt_wr_data = '0, cmp_wr_data = '0;
  logic timer_pend, reeval_stb;
  logic [W-1:0] count_vis;
  int checks = 0;
  int errors = 0;

  always #5 clk = ~clk;

  tick_cmp_timer #(.VIS_W(W)) u0 (
    .clk(clk), .rst_n(rst_n), .step_en(step_en),
    .cnt_wr_en(cnt_wr_en), .cnt_wr_data(cnt_wr_data),
    .cmp_wr_en(cmp_wr_en), .cmp_wr_data(cmp_wr_data),
    .pend_clr(pend_clr), .timer_pend(timer_pend),
    .reeval_stb(reeval_stb), .count_vis(count_vis)
  );

  typedef struct packed {
    logic       st;
    logic       cw;
    logic [7:0] cd;
    logic       mw;
    logic [7:0] md;
    logic       clr;
    logic [7:0] ev;
    logic       ep;
    logic       es;
  } vec_t;

  // step, cnt write, data, cmp write, data, clear -> count, pend, strobe
  localparam vec_t VEC [15] = '{
    '{1'b0,1'b0,8'd0,1'b1,8'd3,1'b0, 8'd0,1'b0,1'b0}, // R5 load compare 3
    '{1'b1,1'b0,8'd0,1'b0,8'd0,1'b0, 8'd0,1'b0,1'b0}, // R2 ctr 1
    '{1'b1,1'b0,8'd0,1'b0,8'd0,1'b0, 8'd1,1'b0,1'b0}, // R2 ctr 2
    '{1'b1,1'b0,8'd0,1'b0,8'd0,1'b0, 8'd1,1'b0,1'b0}, // R2 ctr 3
    '{1'b1,1'b0,8'd0,1'b0,8'd0,1'b0, 8'd2,1'b0,1'b0}, // R2 ctr 4
    '{1'b1,1'b0,8'd0,1'b0,8'd0,1'b0, 8'd2,1'b0,1'b0}, // R2 ctr 5
    '{1'b1,1'b0,8'd0,1'b0,8'd0,1'b0, 8'd3,1'b1,1'b1}, // R6 ctr 6 match
    '{1'b1,1'b0,8'd0,1'b0,8'd0,1'b0, 8'd3,1'b1,1'b0}, // R9 R7 ctr 7
    '{1'b0,1'b0,8'd0,1'b0,8'd0,1'b1, 8'd3,1'b0,1'b0}, // R7 clear
    '{1'b0,1'b1,8'd5,1'b0,8'd0,1'b0, 8'd5,1'b0,1'b0}, // R4 ctr 10
    '{1'b1,1'b1,8'd2,1'b0,8'd0,1'b0, 8'd2,1'b0,1'b0}, // R4 load beats step, ctr 4
    '{1'b1,1'b0,8'd0,1'b0,8'd0,1'b0, 8'd2,1'b0,1'b0}, // R2 ctr 5
    '{1'b1,1'b0,8'd0,1'b0,8'd0,1'b1, 8'd3,1'b1,1'b1}, // R7 match with clear
    '{1'b1,1'b0,8'd0,1'b1,8'd3,1'b0, 8'd3,1'b0,1'b0}, // R5 cmp write clears
    '{1'b0,1'b0,8'd0,1'b0,8'd0,1'b0, 8'd3,1'b0,1'b0}  // R3 hold
  };

  task automatic check(input string req, input logic [W-1:0] ev,
                       input logic ep, input logic es);
    checks++;
    if (count_vis !== ev || timer_pend !== ep || reeval_stb !== es) begin
      errors++;
      $display("FAIL %s: actual count=%0d pend=%b stb=%b expected count=%0d pend=%b stb=%b",
               req, count_vis, timer_pend, reeval_stb, ev, ep, es);
    end
  endtask

  task automatic drive(input logic st, input logic cw, input logic [W-1:0] cd,
                       input logic mw, input logic [W-1:0] md, input logic clr);
    step_en = st; cnt_wr_en = cw; cnt_wr_data = cd;
    cmp_wr_en = mw; cmp_wr_data = md; pend_clr = clr;
    @(posedge clk);
    #1;
    step_en = 1'b0; cnt_wr_en = 1'b0; cmp_wr_en = 1'b0; pend_clr = 1'b0;
  endtask

  initial begin
    #1_000_000;
    errors++;
    checks++;
    $display("FAIL watchdog: actual=hung expected=finished");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    check("R1 in reset", 8'd0, 1'b0, 1'b0);
    rst_n = 1'b1;
    @(posedge clk);
    #1;
    check("R1 after reset", 8'd0, 1'b0, 1'b0);

    for (int i = 0; i < 15; i++) begin
      drive(VEC[i].st, VEC[i].cw, VEC[i].cd, VEC[i].mw, VEC[i].md, VEC[i].clr);
      check($sformatf("vector %0d", i), VEC[i].ev, VEC[i].ep, VEC[i].es);
    end

    // R8: wrap through zero with compare 0
    drive(1'b0, 1'b1, 8'd255, 1'b1, 8'd0, 1'b0);
    check("R8 load top", 8'd255, 1'b0, 1'b0);
    drive(1'b1, 1'b0, 8'd0, 1'b0, 8'd0, 1'b0);
    check("R8 odd phase", 8'd255, 1'b0, 1'b0);
    drive(1'b1, 1'b0, 8'd0, 1'b0, 8'd0, 1'b0);
    check("R8 R6 wrap match", 8'd0, 1'b1, 1'b1);
    drive(1'b0, 1'b0, 8'd0, 1'b0, 8'd0, 1'b0);
    check("R9 R7 idle after match", 8'd0, 1'b1, 1'b0);
    drive(1'b0, 1'b0, 8'd0, 1'b1, 8'd9, 1'b0);
    check("R5 cmp write alone clears", 8'd0, 1'b0, 1'b0);

    // R1: reset mid-run clears compare too
    rst_n = 1'b0;
    @(posedge clk);
    #1;
    check("R1 mid-run reset", 8'd0, 1'b0, 1'b0);
    rst_n = 1'b1;
    @(posedge clk);
    #1;
    drive(1'b0, 1'b1, 8'd255, 1'b0, 8'd0, 1'b0);
    drive(1'b1, 1'b0, 8'd0, 1'b0, 8'd0, 1'b0);
    drive(1'b1, 1'b0, 8'd0, 1'b0, 8'd0, 1'b0);
    check("R1 compare reset to zero", 8'd0, 1'b1, 1'b1);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule